// File: doc/BRIEF.md
# Serial Command Front End for a Digital Potentiometer

This block is the serial slave side of a digitally controlled potentiometer. It runs on the chip's system clock and oversamples the four serial pins (select, clock, data in, pause) through synchronizers. Each transaction is framed by the select line. The first byte identifies the device: a fixed type nibble, three fixed bits and one bit that must match a strap input. The second byte carries a 4-bit opcode and a 2-bit register pointer. Depending on the opcode, the block then accepts a data byte, returns a data byte on a tri-stateable serial output, issues a transfer at once, or enters a stepping mode with no fixed length.

The block does not hold the wiper or the data registers. It issues single-cycle command strobes to a wiper register block and a four-entry data register bank. It reads their current values back through plain input ports. The stepping mode turns every serial clock pulse into an up or down step, depending on the data line. A pause input can freeze the serial sequence and later resume it.

Top module: `dpot_spi_cmd`

## Requirements
- R1: While reset is asserted and after it is released, no strobe is issued and `spi_miso_en` is 0. If the select line is already low when reset is released, commands are ignored until the select line has gone high and then low.
- R2: The first byte after select falls, taken MSB first on rising serial clock, must be `0101` then `110` then the strap bit. On any other value, the rest of the transaction issues no strobe and leaves the serial output undriven.
- R3: The second byte is opcode[7:4], pointer[3:2], with bits [1:0] ignored. An opcode outside the eight listed in R4 to R9 issues no strobe and drives no output.
- R4: Opcode `1010`, followed by a data byte `{2'b00,v}`, produces one `wiper_load` pulse with `wr_data = v`.
- R5: Opcode `1100`, followed by a data byte `{2'b00,v}`, produces one `reg_load` pulse with `wr_data = v` and `reg_sel` equal to the pointer.
- R6: Opcode `1101` produces one `reg_to_wiper` pulse and opcode `1110` one `wiper_to_reg` pulse. Each is issued at the end of the second byte, with `reg_sel` equal to the pointer.
- R7: Opcode `1001` returns `{2'b00, wiper_val}` and opcode `1011` returns `{2'b00, reg_rdata}` for the pointed register. The byte is sent MSB first. The output changes only after a falling serial clock, and the MSB is present after the first falling clock that follows the second byte.
- R8: Opcode `0101` returns a byte of seven zeros with `wr_busy` as its LSB.
- R9: After opcode `0010`, every rising serial clock produces one `step_up` pulse if the data line is high, or one `step_down` pulse if it is low. This continues without limit until select rises.
- R10: `spi_miso_en` is 1 only in the readback phase of a read opcode. It returns to 0 within a few system clocks after select rises.
- R11: Pause low while the serial clock is low freezes the sequence, and clock pulses are then ignored. Pause high while the serial clock is low resumes the sequence at the same bit.
- R12: If select rises before the last bit of a command's final byte, the command is abandoned and no strobe is issued.
- R13: Strobes last one system clock, and at most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_hold_n | input | 1 | Active-low pause |
| addr_strap | input | 1 | Strap bit matched against the ID byte LSB |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_en | output | 1 | Output enable for the serial data pad |
| wiper_val | input | 6 | Current wiper register value |
| reg_rdata | input | 6 | Data register value at `reg_sel` |
| wr_busy | input | 1 | Nonvolatile write in progress |
| reg_sel | output | 2 | Register pointer of the current command |
| wr_data | output | 6 | Value carried by a load strobe |
| wiper_load | output | 1 | Load `wr_data` into the wiper |
| reg_load | output | 1 | Load `wr_data` into register `reg_sel` |
| reg_to_wiper | output | 1 | Copy register `reg_sel` into the wiper |
| wiper_to_reg | output | 1 | Copy the wiper into register `reg_sel` |
| step_up | output | 1 | Move the wiper one tap up |
| step_down | output | 1 | Move the wiper one tap down |

## Verification
The assertions assume that the host keeps the serial clock and the data line stable for several system clocks around every serial clock edge. They also assume that pause changes only while the serial clock is low and that the strap bit is static during a transaction. The stimulus holds every serial level for six system clocks. It changes the data line and pause only while the serial clock is low, and it changes the strap only while select is high. It sweeps all ID byte values and all opcodes, every wiper load value, every register pointer and both status values.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int BYTE_W = 8;
  localparam int VAL_W  = 6;
  localparam int PTR_W  = 2;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int PAD_W  = BYTE_W - VAL_W;

  localparam logic [3:0] ID_TYPE  = 4'b0101;
  localparam logic [2:0] ID_FIXED = 3'b110;

  localparam logic [3:0] OP_STEP      = 4'b0010;
  localparam logic [3:0] OP_STATUS    = 4'b0101;
  localparam logic [3:0] OP_RD_WIPER  = 4'b1001;
  localparam logic [3:0] OP_WR_WIPER  = 4'b1010;
  localparam logic [3:0] OP_RD_REG    = 4'b1011;
  localparam logic [3:0] OP_WR_REG    = 4'b1100;
  localparam logic [3:0] OP_REG2WIPER = 4'b1101;
  localparam logic [3:0] OP_WIPER2REG = 4'b1110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ID, ST_INSTR, ST_WDATA, ST_RDATA, ST_STEP, ST_SKIP
  } phase_e;

  typedef enum logic [1:0] {SRC_WIPER, SRC_REG, SRC_STATUS} rdsrc_e;

  typedef struct packed {
    logic wiper_load;
    logic reg_load;
    logic reg_to_wiper;
    logic wiper_to_reg;
    logic step_up;
    logic step_down;
  } strobe_t;
endpackage

// File: rtl/dpot_in_sync.sv
module dpot_in_sync #(
  parameter int             STAGES  = 2,
  parameter int             W       = 4,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= RST_VAL;
        else        chain_q[0] <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dpot_sck_gate.sv
module dpot_sck_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic hold_s,
  input  logic cs_s,
  output logic rise,
  output logic fall,
  output logic paused
);
  logic sck_d_q;
  logic paused_q, paused_n;

  always_comb begin
    paused_n = paused_q;
    if (cs_s)                 paused_n = 1'b0;
    else if (!sck_s && !hold_s) paused_n = 1'b1;
    else if (!sck_s && hold_s)  paused_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d_q  <= 1'b0;
      paused_q <= 1'b0;
    end else begin
      sck_d_q  <= sck_s;
      paused_q <= paused_n;
    end
  end

  assign rise   = sck_s & ~sck_d_q & ~paused_q & ~cs_s;
  assign fall   = ~sck_s & sck_d_q & ~paused_q & ~cs_s;
  assign paused = paused_q;

  // R11: a pause cannot end while the serial clock is high
  a_r11_pause_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (paused_q && sck_s && !cs_s) |=> paused_q);
endmodule

// File: rtl/dpot_tx_shift.sv
module dpot_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         so
);
  logic [W-1:0] sh_q;
  logic         so_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      so_q <= 1'b0;
    end else if (load) begin
      sh_q <= load_val;
    end else if (shift) begin
      so_q <= sh_q[W-1];
      sh_q <= {sh_q[W-2:0], 1'b0};
    end
  end

  assign so = so_q;

  // R7: the serial output only moves on a falling serial clock
  a_r7_so_changes_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(so_q));
endmodule

// File: rtl/dpot_spi_cmd.sv
module dpot_spi_cmd
  import dpot_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sck,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  input  logic             spi_hold_n,
  input  logic             addr_strap,
  output logic             spi_miso,
  output logic             spi_miso_en,
  input  logic [VAL_W-1:0] wiper_val,
  input  logic [VAL_W-1:0] reg_rdata,
  input  logic             wr_busy,
  output logic [PTR_W-1:0] reg_sel,
  output logic [VAL_W-1:0] wr_data,
  output logic             wiper_load,
  output logic             reg_load,
  output logic             reg_to_wiper,
  output logic             wiper_to_reg,
  output logic             step_up,
  output logic             step_down
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic cs_s, sck_s, si_s, hold_s;
  logic cs_d_q, cs_fall;
  logic rise, fall, paused;

  dpot_in_sync #(.STAGES(SYNC_STAGES), .W(4), .RST_VAL(4'b0001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_cs_n, spi_sck, spi_mosi, spi_hold_n}),
    .q({cs_s, sck_s, si_s, hold_s})
  );

  dpot_sck_gate u_gate (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .hold_s(hold_s), .cs_s(cs_s),
    .rise(rise), .fall(fall), .paused(paused)
  );

  phase_e                 state_q, state_n;
  logic [CNT_W-1:0]       bitcnt_q, bitcnt_n;
  logic [BYTE_W-2:0]      sh_q, sh_n;
  logic [3:0]             op_q, op_n;
  logic [PTR_W-1:0]       ptr_q, ptr_n;
  logic                   ld_pend_q, ld_pend_n;
  rdsrc_e                 ld_src_q, ld_src_n;
  logic                   rd_act_q, rd_act_n;
  logic [VAL_W-1:0]       wdat_q, wdat_n;
  strobe_t                strb_q, strb_n;
  logic [BYTE_W-1:0]      rx_byte;
  logic                   tx_load;
  logic [BYTE_W-1:0]      tx_val;

  assign cs_fall = cs_d_q & ~cs_s;
  assign rx_byte = {sh_q, si_s};

  always_comb begin
    unique case (ld_src_q)
      SRC_WIPER: tx_val = {{PAD_W{1'b0}}, wiper_val};
      SRC_REG:   tx_val = {{PAD_W{1'b0}}, reg_rdata};
      default:   tx_val = {{(BYTE_W-1){1'b0}}, wr_busy};
    endcase
  end

  always_comb begin
    state_n   = state_q;
    bitcnt_n  = bitcnt_q;
    sh_n      = sh_q;
    op_n      = op_q;
    ptr_n     = ptr_q;
    ld_pend_n = ld_pend_q;
    ld_src_n  = ld_src_q;
    rd_act_n  = rd_act_q;
    wdat_n    = wdat_q;
    strb_n    = '0;
    tx_load   = 1'b0;
    if (cs_s) begin
      state_n   = ST_IDLE;
      bitcnt_n  = '0;
      ld_pend_n = 1'b0;
      rd_act_n  = 1'b0;
    end else if (cs_fall) begin
      state_n   = ST_ID;
      bitcnt_n  = '0;
      ld_pend_n = 1'b0;
      rd_act_n  = 1'b0;
    end else begin
      if (ld_pend_q) begin
        tx_load   = 1'b1;
        ld_pend_n = 1'b0;
        rd_act_n  = 1'b1;
      end
      if (rise) begin
        unique case (state_q)
          ST_ID, ST_INSTR, ST_WDATA, ST_RDATA: begin
            sh_n     = rx_byte[BYTE_W-2:0];
            bitcnt_n = bitcnt_q + 1'b1;
            if (bitcnt_q == LAST_BIT) begin
              unique case (state_q)
                ST_ID: begin
                  if (rx_byte == {ID_TYPE, ID_FIXED, addr_strap}) state_n = ST_INSTR;
                  else                                            state_n = ST_SKIP;
                end
                ST_INSTR: begin
                  op_n    = rx_byte[7:4];
                  ptr_n   = rx_byte[3:2];
                  state_n = ST_SKIP;
                  unique case (rx_byte[7:4])
                    OP_RD_WIPER: begin ld_pend_n = 1'b1; ld_src_n = SRC_WIPER;  state_n = ST_RDATA; end
                    OP_RD_REG:   begin ld_pend_n = 1'b1; ld_src_n = SRC_REG;    state_n = ST_RDATA; end
                    OP_STATUS:   begin ld_pend_n = 1'b1; ld_src_n = SRC_STATUS; state_n = ST_RDATA; end
                    OP_WR_WIPER, OP_WR_REG: state_n = ST_WDATA;
                    OP_REG2WIPER: strb_n.reg_to_wiper = 1'b1;
                    OP_WIPER2REG: strb_n.wiper_to_reg = 1'b1;
                    OP_STEP:      state_n = ST_STEP;
                    default: ;
                  endcase
                end
                ST_WDATA: begin
                  wdat_n  = rx_byte[VAL_W-1:0];
                  state_n = ST_SKIP;
                  if (op_q == OP_WR_WIPER) strb_n.wiper_load = 1'b1;
                  else                     strb_n.reg_load   = 1'b1;
                end
                default: state_n = ST_SKIP;
              endcase
            end
          end
          ST_STEP: begin
            if (si_s) strb_n.step_up   = 1'b1;
            else      strb_n.step_down = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d_q    <= 1'b0;
      state_q   <= ST_IDLE;
      bitcnt_q  <= '0;
      sh_q      <= '0;
      op_q      <= '0;
      ptr_q     <= '0;
      ld_pend_q <= 1'b0;
      ld_src_q  <= SRC_WIPER;
      rd_act_q  <= 1'b0;
      wdat_q    <= '0;
      strb_q    <= '0;
    end else begin
      cs_d_q    <= cs_s;
      state_q   <= state_n;
      bitcnt_q  <= bitcnt_n;
      sh_q      <= sh_n;
      op_q      <= op_n;
      ptr_q     <= ptr_n;
      ld_pend_q <= ld_pend_n;
      ld_src_q  <= ld_src_n;
      rd_act_q  <= rd_act_n;
      wdat_q    <= wdat_n;
      strb_q    <= strb_n;
    end
  end

  dpot_tx_shift #(.W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .load_val(tx_val),
    .shift(fall & rd_act_q), .so(spi_miso)
  );

  assign spi_miso_en  = rd_act_q & ~cs_s;
  assign reg_sel      = ptr_q;
  assign wr_data      = wdat_q;
  assign wiper_load   = strb_q.wiper_load;
  assign reg_load     = strb_q.reg_load;
  assign reg_to_wiper = strb_q.reg_to_wiper;
  assign wiper_to_reg = strb_q.wiper_to_reg;
  assign step_up      = strb_q.step_up;
  assign step_down    = strb_q.step_down;

  // R13: strobes are mutually exclusive
  a_r13_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb_q));

  // R12: a strobe is only issued from a cycle with select low
  a_r12_strobe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (|strb_q) |-> !$past(cs_s));

  // R9: step strobes only come from the stepping phase
  a_r9_step_from_step_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_q.step_up || strb_q.step_down) |-> $past(state_q == ST_STEP));

  // R11: while paused the receive shifter and bit count hold
  a_r11_pause_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !cs_s && !cs_fall) |=> ($stable(bitcnt_q) && $stable(sh_q)));

  // R10: the output is only driven in a read phase
  a_r10_drive_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    spi_miso_en |-> (state_q == ST_RDATA || state_q == ST_SKIP));

  // R1: no transaction starts without a falling select
  a_r1_idle_until_cs_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !cs_fall) |=> state_q == ST_IDLE);
endmodule

// File: tb/test_dpot_spi_cmd.sv
module test_dpot_spi_cmd;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b0, mosi = 1'b0, hold_n = 1'b1, strap = 1'b1;
  logic miso, miso_en;
  logic [5:0] env_wiper = 6'd0;
  logic [5:0] env_regs [4];
  logic busy = 1'b0;
  logic [1:0] reg_sel;
  logic [5:0] wr_data;
  logic wl, rl, r2w, w2r, up, dn;

  int n_cmp = 0, n_bad = 0;
  int cnt [6];
  int base [6];
  int cnt_multi = 0;
  logic [5:0] last_data;
  logic [1:0] last_sel;
  logic last_en;

  always #2.5 clk = ~clk;

  dpot_spi_cmd i_dpot_spi_cmd (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_hold_n(hold_n), .addr_strap(strap), .spi_miso(miso), .spi_miso_en(miso_en),
    .wiper_val(env_wiper), .reg_rdata(env_regs[reg_sel]), .wr_busy(busy),
    .reg_sel(reg_sel), .wr_data(wr_data), .wiper_load(wl), .reg_load(rl),
    .reg_to_wiper(r2w), .wiper_to_reg(w2r), .step_up(up), .step_down(dn)
  );

  initial begin
    for (int i = 0; i < 6; i++) cnt[i] = 0;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (wl)  cnt[0] <= cnt[0] + 1;
      if (rl)  cnt[1] <= cnt[1] + 1;
      if (r2w) cnt[2] <= cnt[2] + 1;
      if (w2r) cnt[3] <= cnt[3] + 1;
      if (up)  cnt[4] <= cnt[4] + 1;
      if (dn)  cnt[5] <= cnt[5] + 1;
      if ($countones({wl, rl, r2w, w2r, up, dn}) > 1) cnt_multi <= cnt_multi + 1;
      if (wl | rl | r2w | w2r) begin
        last_data <= wr_data;
        last_sel  <= reg_sel;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic snap();
    for (int i = 0; i < 6; i++) base[i] = cnt[i];
  endtask

  function automatic int dlt(input int i);
    return cnt[i] - base[i];
  endfunction

  function automatic int dsum();
    int s = 0;
    for (int i = 0; i < 6; i++) s += cnt[i] - base[i];
    return s;
  endfunction

  task automatic sck_bit(input logic b, output logic r);
    mosi = b;
    repeat (6) @(negedge clk);
    r = miso;
    last_en = miso_en;
    sck = 1'b1;
    repeat (6) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) sck_bit(tx[i], rx[i]);
  endtask

  task automatic cs_low();
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  function automatic logic [7:0] id_byte(input logic a);
    return {4'b0101, 3'b110, a};
  endfunction

  initial begin : wdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] rx;
    logic r;
    env_regs[0] = 6'h05; env_regs[1] = 6'h3A; env_regs[2] = 6'h21; env_regs[3] = 6'h3F;
    repeat (5) @(negedge clk);
    chk("R1 miso_en in reset", miso_en, 0);
    chk("R1 wiper_load in reset", wl, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 miso_en after reset", miso_en, 0);
    // R1: select low since reset, no falling edge seen
    snap();
    send_byte(id_byte(1'b1), rx);
    send_byte(8'hA0, rx);
    send_byte(8'h15, rx);
    repeat (6) @(negedge clk);
    chk("R1 no strobe without cs fall", dsum(), 0);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);

    // R4: every wiper value
    for (int v = 0; v < 64; v++) begin
      snap();
      cs_low();
      send_byte(id_byte(1'b1), rx);
      send_byte(8'hA0, rx);
      send_byte({2'b00, 6'(v)}, rx);
      cs_high();
      chk("R4 wiper_load count", dlt(0), 1);
      chk("R4 wiper data", last_data, v);
    end

    // R5: data register writes
    for (int p = 0; p < 4; p++) begin
      snap();
      cs_low();
      send_byte(id_byte(1'b1), rx);
      send_byte({4'b1100, 2'(p), 2'b00}, rx);
      send_byte({2'b00, 6'(p * 13 + 5)}, rx);
      cs_high();
      chk("R5 reg_load count", dlt(1), 1);
      chk("R5 reg data", last_data, p * 13 + 5);
      chk("R5 reg pointer", last_sel, p);
    end

    // R6: transfers in both directions
    for (int p = 0; p < 4; p++) begin
      snap();
      cs_low();
      send_byte(id_byte(1'b1), rx);
      send_byte({4'b1101, 2'(p), 2'b00}, rx);
      cs_high();
      chk("R6 reg_to_wiper count", dlt(2), 1);
      chk("R6 reg_to_wiper pointer", last_sel, p);
      snap();
      cs_low();
      send_byte(id_byte(1'b1), rx);
      send_byte({4'b1110, 2'(p), 2'b00}, rx);
      cs_high();
      chk("R6 wiper_to_reg count", dlt(3), 1);
      chk("R6 wiper_to_reg pointer", last_sel, p);
    end

    // R7: wiper readback
    for (int k = 0; k < 4; k++) begin
      env_wiper = (k == 0) ? 6'h00 : (k == 1) ? 6'h3F : (k == 2) ? 6'h2A : 6'h15;
      cs_low();
      send_byte(id_byte(1'b1), rx);
      send_byte(8'h90, rx);
      send_byte(8'h00, rx);
      chk("R7 wiper readback", rx, {2'b00, env_wiper});
      chk("R10 driven during read", last_en, 1);
      cs_high();
      chk("R10 released after cs rise", miso_en, 0);
    end

    // R7: data register readback
    for (int p = 0; p < 4; p++) begin
      cs_low();
      send_byte(id_byte(1'b1), rx);
      send_byte({4'b1011, 2'(p), 2'b00}, rx);
      send_byte(8'h00, rx);
      chk("R7 register readback", rx, {2'b00, env_regs[p]});
      cs_high();
    end

    // R8: status
    for (int b = 0; b < 2; b++) begin
      busy = 1'(b);
      cs_low();
      send_byte(id_byte(1'b1), rx);
      send_byte(8'h50, rx);
      send_byte(8'h00, rx);
      chk("R8 status byte", rx, b);
      cs_high();
    end
    busy = 1'b0;

    // R9: long stepping run
    begin
      logic [39:0] pat;
      pat = 40'hA5_C31E_7B96;
      snap();
      cs_low();
      send_byte(id_byte(1'b1), rx);
      send_byte(8'h20, rx);
      for (int i = 0; i < 40; i++) sck_bit(pat[i], r);
      cs_high();
      chk("R9 step_up count", dlt(4), $countones(pat));
      chk("R9 step_down count", dlt(5), 40 - $countones(pat));
    end

    // R2: sweep of all ID byte values, followed by a transfer opcode
    for (int id = 0; id < 256; id++) begin
      snap();
      cs_low();
      send_byte(8'(id), rx);
      send_byte(8'hD4, rx);
      cs_high();
      chk("R2 id match", dlt(2), (id == 8'h5D) ? 1 : 0);
    end

    // R2: strap low accepts only the matching ID
    strap = 1'b0;
    snap();
    cs_low();
    send_byte(id_byte(1'b1), rx);
    send_byte(8'h90, rx);
    send_byte(8'h00, rx);
    chk("R2 mismatched read leaves output off", last_en, 0);
    cs_high();
    cs_low();
    send_byte(id_byte(1'b0), rx);
    send_byte(8'hA0, rx);
    send_byte(8'h2C, rx);
    cs_high();
    chk("R2 strap low match", dlt(0), 1);
    chk("R2 strap low data", last_data, 6'h2C);
    strap = 1'b1;

    // R3: all opcodes, pointer 01, then data byte 0x2A
    for (int op = 0; op < 16; op++) begin
      int e [6];
      int erd;
      for (int i = 0; i < 6; i++) e[i] = 0;
      erd = 0;
      case (op)
        4'b1010: e[0] = 1;
        4'b1100: e[1] = 1;
        4'b1101: e[2] = 1;
        4'b1110: e[3] = 1;
        4'b0010: begin e[4] = 3; e[5] = 5; end
        4'b1001, 4'b1011, 4'b0101: erd = 1;
        default: ;
      endcase
      snap();
      cs_low();
      send_byte(id_byte(1'b1), rx);
      send_byte({4'(op), 2'b01, 2'b00}, rx);
      send_byte(8'h2A, rx);
      chk("R3 R10 output enable by opcode", last_en, erd);
      cs_high();
      for (int i = 0; i < 6; i++) chk("R3 strobes by opcode", dlt(i), e[i]);
    end

    // R11: pause inside the ID byte with ignored pulses
    snap();
    cs_low();
    sck_bit(1'b0, r); sck_bit(1'b1, r); sck_bit(1'b0, r);
    hold_n = 1'b0;
    repeat (6) @(negedge clk);
    sck_bit(1'b1, r); sck_bit(1'b1, r);
    hold_n = 1'b1;
    repeat (6) @(negedge clk);
    sck_bit(1'b1, r); sck_bit(1'b1, r); sck_bit(1'b1, r); sck_bit(1'b0, r); sck_bit(1'b1, r);
    send_byte(8'hA0, rx);
    send_byte(8'h33, rx);
    cs_high();
    chk("R11 paused write count", dlt(0), 1);
    chk("R11 paused write data", last_data, 6'h33);

    // R12: abort inside data byte and inside instruction byte
    snap();
    cs_low();
    send_byte(id_byte(1'b1), rx);
    send_byte(8'hA0, rx);
    for (int i = 0; i < 4; i++) sck_bit(1'b1, r);
    cs_high();
    chk("R12 abort in data byte", dsum(), 0);
    snap();
    cs_low();
    send_byte(id_byte(1'b1), rx);
    for (int i = 0; i < 7; i++) sck_bit(i[0], r);
    cs_high();
    chk("R12 abort in instruction byte", dsum(), 0);
    snap();
    cs_low();
    send_byte(id_byte(1'b1), rx);
    send_byte(8'hA0, rx);
    send_byte(8'h0F, rx);
    cs_high();
    chk("R12 recovery after abort", last_data, 6'h0F);

    chk("R13 overlapping strobes", cnt_multi, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule